// File: doc/BRIEF.md
# SPI Transmit/Receive Data Buffer

This block sits between the register side of an SPI controller and its serial shift engine and holds the data words in flight in both directions. Software pushes transmit words and the shift engine pops them. The shift engine pushes received words and software pops them. Each direction is a small first-in-first-out store with a default depth of four words. Either direction can be switched to a direct mode, in which it keeps a single word and behaves as a plain double-buffered path.

A single configuration register sets the behaviour. Bit 0 (`off`) freezes the data path, so that pushes, pops and flushes have no effect and all status holds. Bit 1 (`tx_direct`) and bit 2 (`rx_direct`) select direct mode for transmit and receive. These two bits can only be changed while `off` reads 0. Bit 3 and bit 4 are write-one flush strobes for transmit and receive. They empty the store in the same cycle and always read back as 0. Bits 15:5 are reserved.

Top module: `spi_fifo_buf`

## Requirements
- R1: After reset, `off` equals the `OFF_AT_RESET` parameter (default 0), both direct bits are 0, `cfg_rdata` reads 0, both counts are 0, both `*_empty` flags are 1 and both `*_full` flags are 0.
- R2: In FIFO mode (direct bit 0), words leave a direction in the order they entered, `*_head` shows the oldest stored word, and `*_count` gives the number of stored words.
- R3: In FIFO mode a direction reports full at `DEPTH` words. A push while full and a pop while empty are dropped and change nothing.
- R4: With the direct bit set (bit 1 for transmit, bit 2 for receive), the capacity is one word. Full rises after one push, further pushes are dropped, and full clears on the pop.
- R5: A write to bits 1 and 2 takes effect only if `off` is 0 before that write. Otherwise both direct bits keep their values. Bit 0 is always written.
- R6: Writing 1 to bit 3 (transmit) or bit 4 (receive) leaves that direction empty one cycle later. A push or pop in the same cycle is discarded.
- R7: `cfg_rdata` returns `off`, `tx_direct` and `rx_direct` in bits 0, 1 and 2. All other bits, including the flush strobes, read 0 and ignore writes.
- R8: While `off` is 1, pushes, pops and flush strobes are ignored, and counts, flags and head words hold.
- R9: A push and a pop in the same cycle, on a direction that is neither empty nor full, leave the count unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | REG_W | Configuration write value |
| cfg_rdata | output | REG_W | Configuration read value |
| tx_push | input | 1 | Software pushes a transmit word |
| tx_push_data | input | DATA_W | Transmit word to store |
| tx_pop | input | 1 | Shift engine takes the transmit head |
| tx_head | output | DATA_W | Oldest transmit word |
| tx_count | output | $clog2(DEPTH+1) | Stored transmit words |
| tx_empty | output | 1 | Transmit store empty |
| tx_full | output | 1 | Transmit store at capacity |
| rx_push | input | 1 | Shift engine pushes a received word |
| rx_push_data | input | DATA_W | Received word to store |
| rx_pop | input | 1 | Software takes the receive head |
| rx_head | output | DATA_W | Oldest received word |
| rx_count | output | $clog2(DEPTH+1) | Stored receive words |
| rx_empty | output | 1 | Receive store empty |
| rx_full | output | 1 | Receive store at capacity |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. A push, pop, flush or register write presented before an edge shows up in the counts, flags, head word and `cfg_rdata` just after that edge. The status outputs are Moore outputs of the stored state, and `cfg_rdata` depends only on register state. The bench therefore drives inputs on the falling edge, advances a behavioural queue model by one step for each rising edge, and compares every output on the following falling edge. The bench has no tolerance window, so a result that arrives one cycle early or one cycle late is reported.

// File: rtl/spibuf_pkg.sv
package spibuf_pkg;
    localparam int OFF_BIT = 0;
    localparam int TXD_BIT = 1;
    localparam int RXD_BIT = 2;
    localparam int TXF_BIT = 3;
    localparam int RXF_BIT = 4;

    typedef struct packed {
        logic off;
        logic tx_direct;
        logic rx_direct;
    } spibuf_cfg_t;
endpackage

// File: rtl/spibuf_cfg.sv
module spibuf_cfg
    import spibuf_pkg::*;
#(
    parameter int REG_W        = 16,
    parameter bit OFF_AT_RESET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output spibuf_cfg_t      cfg,
    output logic             tx_flush,
    output logic             rx_flush
);
    spibuf_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.off = wdata[OFF_BIT];
            if (!cfg_q.off) begin
                cfg_d.tx_direct = wdata[TXD_BIT];
                cfg_d.rx_direct = wdata[RXD_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{off: OFF_AT_RESET, tx_direct: 1'b0, rx_direct: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // flush strobes are pulses only; they never reach storage
    assign tx_flush = we && wdata[TXF_BIT] && !cfg_q.off;
    assign rx_flush = we && wdata[RXF_BIT] && !cfg_q.off;

    always_comb begin
        rdata          = '0;
        rdata[OFF_BIT] = cfg_q.off;
        rdata[TXD_BIT] = cfg_q.tx_direct;
        rdata[RXD_BIT] = cfg_q.rx_direct;
    end

    assign cfg = cfg_q;

    assert_direct_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.off && we) |=> ($stable(cfg_q.tx_direct) && $stable(cfg_q.rx_direct)));
endmodule

// File: rtl/spibuf_fifo.sv
module spibuf_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       direct,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       pop,
    output logic [DATA_W-1:0]          head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PW-1:0]                wr;
        logic [PW-1:0]                rd;
        logic [CW-1:0]                cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [CW-1:0] cap;
    logic do_push, do_pop;

    assign cap     = direct ? CW'(1) : CW'(DEPTH);
    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt >= cap);
    assign do_push = en && !flush && push && !full;
    assign do_pop  = en && !flush && pop && !empty;

    always_comb begin
        st_d = st_q;
        if (en && flush) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
            end
            if (do_pop) begin
                st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    assert_direct_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && direct && !flush && push && !pop && st_q.cnt != '0) |=> $stable(st_q.cnt));
    assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && flush) |=> (st_q.cnt == '0));
    assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(st_q.cnt) && $stable(st_q.rd) && $stable(st_q.wr)));
    assert_swap_keeps_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !flush && push && pop && !full && !empty) |=> $stable(st_q.cnt));
endmodule

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf
    import spibuf_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int DEPTH        = 4,
    parameter int REG_W        = 16,
    parameter bit OFF_AT_RESET = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [REG_W-1:0]           cfg_wdata,
    output logic [REG_W-1:0]           cfg_rdata,
    input  logic                       tx_push,
    input  logic [DATA_W-1:0]          tx_push_data,
    input  logic                       tx_pop,
    output logic [DATA_W-1:0]          tx_head,
    output logic [$clog2(DEPTH+1)-1:0] tx_count,
    output logic                       tx_empty,
    output logic                       tx_full,
    input  logic                       rx_push,
    input  logic [DATA_W-1:0]          rx_push_data,
    input  logic                       rx_pop,
    output logic [DATA_W-1:0]          rx_head,
    output logic [$clog2(DEPTH+1)-1:0] rx_count,
    output logic                       rx_empty,
    output logic                       rx_full
);
    spibuf_cfg_t cfg;
    logic tx_flush, rx_flush;
    logic path_en;

    spibuf_cfg #(.REG_W(REG_W), .OFF_AT_RESET(OFF_AT_RESET)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .cfg(cfg), .tx_flush(tx_flush), .rx_flush(rx_flush)
    );

    assign path_en = !cfg.off;

    spibuf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(path_en), .direct(cfg.tx_direct),
        .flush(tx_flush), .push(tx_push), .push_data(tx_push_data), .pop(tx_pop),
        .head(tx_head), .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    spibuf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(path_en), .direct(cfg.rx_direct),
        .flush(rx_flush), .push(rx_push), .push_data(rx_push_data), .pop(rx_pop),
        .head(rx_head), .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata[REG_W-1:3] == '0));
endmodule

// File: tb/spi_fifo_buf_test.sv
module spi_fifo_buf_test;
    localparam int DW  = 8;
    localparam int DEP = 4;
    localparam int RW  = 16;
    localparam int CW  = $clog2(DEP + 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic cfg_we;
    logic [RW-1:0] cfg_wdata, cfg_rdata;
    logic tx_push, tx_pop, rx_push, rx_pop;
    logic [DW-1:0] tx_push_data, rx_push_data, tx_head, rx_head;
    logic [CW-1:0] tx_count, rx_count;
    logic tx_empty, tx_full, rx_empty, rx_full;

    spi_fifo_buf uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop), .tx_head(tx_head),
        .tx_count(tx_count), .tx_empty(tx_empty), .tx_full(tx_full),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop), .rx_head(rx_head),
        .rx_count(rx_count), .rx_empty(rx_empty), .rx_full(rx_full)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    bit m_off, m_td, m_rd;
    logic [DW-1:0] txq[$];
    logic [DW-1:0] rxq[$];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] exp_rdata();
        logic [RW-1:0] v = '0;
        v[0] = m_off; v[1] = m_td; v[2] = m_rd;
        return v;
    endfunction

    task automatic compare();
        int tcap = m_td ? 1 : DEP;
        int rcap = m_rd ? 1 : DEP;
        chk("R7", "cfg_rdata", 32'(cfg_rdata), 32'(exp_rdata()));
        chk("R2", "tx_count", 32'(tx_count), 32'(txq.size()));
        chk("R2", "rx_count", 32'(rx_count), 32'(rxq.size()));
        chk("R3", "tx_empty", 32'(tx_empty), 32'(txq.size() == 0));
        chk("R3", "rx_empty", 32'(rx_empty), 32'(rxq.size() == 0));
        chk(m_td ? "R4" : "R3", "tx_full", 32'(tx_full), 32'(txq.size() >= tcap));
        chk(m_rd ? "R4" : "R3", "rx_full", 32'(rx_full), 32'(rxq.size() >= rcap));
        if (txq.size() > 0) chk("R2", "tx_head", 32'(tx_head), 32'(txq[0]));
        if (rxq.size() > 0) chk("R2", "rx_head", 32'(rx_head), 32'(rxq[0]));
    endtask

    task automatic step_q(ref logic [DW-1:0] q[$], input bit direct, input bit flush,
                          input bit push, input logic [DW-1:0] d, input bit pop);
        int cap = direct ? 1 : DEP;
        bit canpush = push && (q.size() < cap);
        bit canpop  = pop && (q.size() > 0);
        if (m_off) return;
        if (flush) begin
            q.delete();
            return;
        end
        if (canpop) void'(q.pop_front());
        if (canpush) q.push_back(d);
    endtask

    // drive at the falling edge, model one rising edge, compare at the next falling edge
    task automatic cyc(bit we, logic [RW-1:0] wd, bit tp, logic [DW-1:0] td, bit tpo,
                       bit rp, logic [DW-1:0] rd, bit rpo);
        bit old_off;
        cfg_we = we; cfg_wdata = wd;
        tx_push = tp; tx_push_data = td; tx_pop = tpo;
        rx_push = rp; rx_push_data = rd; rx_pop = rpo;
        step_q(txq, m_td, we && wd[3], tp, td, tpo);
        step_q(rxq, m_rd, we && wd[4], rp, rd, rpo);
        old_off = m_off;
        if (we) begin
            m_off = wd[0];
            if (!old_off) begin
                m_td = wd[1];
                m_rd = wd[2];
            end
        end
        @(posedge clk);
        @(negedge clk);
        cfg_we = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        compare();
    endtask

    task automatic idle();
        cyc(0, '0, 0, '0, 0, 0, '0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_wdata = '0;
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        tx_push_data = '0; rx_push_data = '0;
        m_off = 0; m_td = 0; m_rd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset cfg_rdata", 32'(cfg_rdata), 32'h0);
        chk("R1", "reset tx_count", 32'(tx_count), 32'h0);
        chk("R1", "reset rx_count", 32'(rx_count), 32'h0);
        chk("R1", "reset empties", {30'b0, tx_empty, rx_empty}, 32'h3);
        chk("R1", "reset fulls", {30'b0, tx_full, rx_full}, 32'h0);

        // R2/R3 transmit ordering and full
        for (int i = 0; i < DEP + 1; i++) cyc(0, '0, 1, DW'(8'hA0 + i), 0, 0, '0, 0);
        chk("R3", "tx full at depth", 32'(tx_full), 32'h1);
        chk("R3", "tx count after overpush", 32'(tx_count), 32'(DEP));
        for (int i = 0; i < DEP; i++) begin
            chk("R2", "tx order", 32'(tx_head), 32'(8'hA0 + i));
            cyc(0, '0, 0, '0, 1, 0, '0, 0);
        end
        cyc(0, '0, 0, '0, 1, 0, '0, 0);
        chk("R3", "tx pop while empty", 32'(tx_count), 32'h0);

        // R2 receive ordering
        for (int i = 0; i < 3; i++) cyc(0, '0, 0, '0, 0, 1, DW'(8'h50 + i), 0);
        for (int i = 0; i < 3; i++) begin
            chk("R2", "rx order", 32'(rx_head), 32'(8'h50 + i));
            cyc(0, '0, 0, '0, 0, 0, '0, 1);
        end

        // R9 simultaneous push and pop
        cyc(0, '0, 1, 8'h11, 0, 0, '0, 0);
        cyc(0, '0, 1, 8'h22, 0, 0, '0, 0);
        cyc(0, '0, 1, 8'h33, 1, 0, '0, 0);
        chk("R9", "tx count on swap", 32'(tx_count), 32'h2);
        chk("R9", "tx head on swap", 32'(tx_head), 32'h22);
        cyc(1, 16'h0008, 0, '0, 0, 0, '0, 0);

        // R4 direct mode on transmit
        cyc(1, 16'h0002, 0, '0, 0, 0, '0, 0);
        cyc(0, '0, 1, 8'h77, 0, 0, '0, 0);
        chk("R4", "tx full after one push", 32'(tx_full), 32'h1);
        cyc(0, '0, 1, 8'h78, 0, 0, '0, 0);
        chk("R4", "tx direct keeps one", 32'(tx_count), 32'h1);
        chk("R4", "tx direct head", 32'(tx_head), 32'h77);
        cyc(0, '0, 0, '0, 1, 0, '0, 0);
        chk("R4", "tx full clears on pop", 32'(tx_full), 32'h0);
        cyc(1, 16'h0004, 0, '0, 0, 1, 8'h99, 0);
        cyc(0, '0, 0, '0, 0, 1, 8'h9A, 0);
        chk("R4", "rx direct keeps one", 32'(rx_count), 32'h1);
        cyc(1, 16'h0000, 0, '0, 0, 0, '0, 1);

        // R6 flush beats a same-cycle push
        for (int i = 0; i < 3; i++) cyc(0, '0, 0, '0, 0, 1, DW'(i + 1), 0);
        cyc(1, 16'h0010, 0, '0, 0, 1, 8'hEE, 0);
        chk("R6", "rx count after flush", 32'(rx_count), 32'h0);
        chk("R6", "rx empty after flush", 32'(rx_empty), 32'h1);

        // R7 flush and reserved bits read 0
        cyc(1, 16'hFFF8, 0, '0, 0, 0, '0, 0);
        chk("R7", "readback after 0xFFF8", 32'(cfg_rdata), 32'h0);

        // R8 freeze, R5 lock
        cyc(0, '0, 1, 8'h3C, 0, 0, '0, 0);
        cyc(1, 16'h0001, 0, '0, 0, 0, '0, 0);
        cyc(0, '0, 1, 8'h3D, 0, 1, 8'h3E, 0);
        chk("R8", "tx count frozen", 32'(tx_count), 32'h1);
        chk("R8", "rx count frozen", 32'(rx_count), 32'h0);
        cyc(0, '0, 0, '0, 1, 0, '0, 0);
        chk("R8", "tx pop ignored", 32'(tx_head), 32'h3C);
        cyc(1, 16'h0009, 0, '0, 0, 0, '0, 0);
        chk("R8", "flush ignored while off", 32'(tx_count), 32'h1);
        cyc(1, 16'h0006, 0, '0, 0, 0, '0, 0);
        chk("R5", "direct bits locked", 32'(cfg_rdata), 32'h0);
        cyc(1, 16'h0006, 0, '0, 0, 0, '0, 0);
        chk("R5", "direct bits written when on", 32'(cfg_rdata), 32'h6);
        cyc(1, 16'h0018, 0, '0, 0, 0, '0, 0);

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            bit we = ($urandom_range(0, 15) == 0);
            logic [RW-1:0] wd = RW'($urandom);
            if ($urandom_range(0, 2) != 0) wd[0] = 1'b0;
            if ($urandom_range(0, 3) != 0) wd[4:3] = 2'b00;
            cyc(we, wd, 1'($urandom), DW'($urandom), 1'($urandom),
                1'($urandom), DW'($urandom), 1'($urandom));
        end
        idle();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule